// File: doc/BRIEF.md
# Stereo Attenuator with Ramped Soft Mute

This block scales a stream of stereo sample frames by two independent linear gains, one per channel, ahead of a digital-to-analog conversion path. Each accepted frame carries one signed 24-bit left sample and one signed 24-bit right sample, marked by a single valid strobe. The scaled pair appears one clock later with its own valid strobe.

The gain actually applied never jumps. It walks toward its target by one step on each accepted frame, so a new volume setting, a mute or an unmute becomes a gradual fade rather than a click. The target is the programmed 14-bit volume. It becomes zero whenever the register mute bit or the external mute pin is high. A polarity control flips the sign of both channels, saturating where the negative full-scale code has no positive twin.

A silence detector watches the incoming samples and raises a flag once both channels have stayed at zero for longer than a fixed number of frames.

Top module: `stereo_gain_stage`

## Requirements
- R1: After reset, `out_left`, `out_right`, `out_valid` and `zero_flag` are 0, and both applied gains are at full scale, 16383.
- R2: A frame accepted on a rising edge with `in_valid` high produces `out_valid` high one cycle later. In that cycle each output holds (sample × g) / 16384 rounded toward zero, where g is that channel's applied gain before this frame's ramp step. A cycle without `in_valid` gives `out_valid` low.
- R3: On each accepted frame the applied gain moves one step toward its target: up by 1 if below, down by 1 if above, unchanged if equal. The gain does not change in a cycle without `in_valid`.
- R4: The left gain follows `vol_left` and the right gain follows `vol_right`, independently of each other.
- R5: While `soft_mute` is 1 both targets are 0, so both gains ramp down to zero and the outputs become 0. When `soft_mute` returns to 0, the gains ramp back up to the programmed volumes.
- R6: While `hard_mute` is 1 both targets are 0, exactly as for `soft_mute`. Either input alone mutes.
- R7: With `flip_polarity` at 1, each sample is negated before scaling, and an input of −8388608 is treated as +8388607. With `flip_polarity` at 0, no negation is applied.
- R8: `zero_flag` becomes 1 after the 1025th consecutive accepted frame in which both samples are zero, and it stays 1 while further all-zero frames arrive.
- R9: `zero_flag` returns to 0 after the first accepted frame in which either sample is nonzero. That frame also restarts the count of zero frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Frame strobe for the input samples |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| vol_left | input | 14 | Left target volume, unsigned, 16383 = full |
| vol_right | input | 14 | Right target volume, unsigned |
| soft_mute | input | 1 | Register mute request, 1 = mute |
| hard_mute | input | 1 | Mute pin, 1 = mute |
| flip_polarity | input | 1 | 1 = invert both outputs |
| out_valid | output | 1 | Strobe for the scaled samples |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| zero_flag | output | 1 | Both channels silent beyond the frame limit |

## Verification
The bench follows every frame of long ramps with an arithmetic model of gain and rounding. A design that stepped the gain at once, stepped it twice, or stepped it on idle cycles would therefore miscompare on the very next frame. Negative samples with small gains target rounding, where flooring instead of truncation would give −1 for −1 × 16383 / 16384. The negative full-scale code is driven with inversion enabled at full gain, where a missing saturation would wrap to a large negative value. The silence detector is checked on both sides of its 1024-frame boundary, so an off-by-one count shows up. It is also checked with only one channel nonzero, so a detector that watched only one channel would fail to clear.

// File: rtl/sgs_pkg.sv
package sgs_pkg;

    localparam int DATA_W = 24;
    localparam int VOL_W  = 14;
    localparam int PROD_W = DATA_W + VOL_W + 1;

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic        [VOL_W-1:0]  gain_t;

    localparam sample_t SMP_MAX   = {1'b0, {(DATA_W-1){1'b1}}};
    localparam sample_t SMP_MIN   = {1'b1, {(DATA_W-1){1'b0}}};
    localparam gain_t   GAIN_FULL = '1;
    localparam gain_t   GAIN_ZERO = '0;

    typedef struct packed {
        logic    valid;
        sample_t left;
        sample_t right;
    } frame_t;

    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_UP   = 2'd1,
        RAMP_DOWN = 2'd2
    } ramp_dir_t;

    // Negate, clamping the one code whose negation does not fit.
    function automatic sample_t neg_sat(input sample_t x);
        return (x == SMP_MIN) ? SMP_MAX : -x;
    endfunction

    // x * g / 2**VOL_W, truncated toward zero.
    function automatic sample_t apply_gain(input sample_t x, input gain_t g);
        logic signed [PROD_W-1:0] xs;
        logic signed [PROD_W-1:0] gs;
        logic signed [PROD_W-1:0] prod;
        logic signed [PROD_W-1:0] bias;
        logic signed [PROD_W-1:0] shifted;
        xs      = PROD_W'(x);
        gs      = $signed({{(DATA_W+1){1'b0}}, g});
        prod    = xs * gs;
        bias    = prod[PROD_W-1] ? $signed({{(DATA_W+1){1'b0}}, GAIN_FULL}) : '0;
        shifted = (prod + bias) >>> VOL_W;
        return shifted[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/sgs_gain_ramp.sv
module sgs_gain_ramp
    import sgs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  advance,
    input  logic  mute,
    input  gain_t volume,
    output gain_t gain
);

    gain_t     gain_q;
    gain_t     target;
    ramp_dir_t dir;

    always_comb begin
        target = mute ? GAIN_ZERO : volume;
        if (gain_q < target)
            dir = RAMP_UP;
        else if (gain_q > target)
            dir = RAMP_DOWN;
        else
            dir = RAMP_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_q <= GAIN_FULL;
        end else if (advance) begin
            case (dir)
                RAMP_UP:   gain_q <= gain_q + gain_t'(1);
                RAMP_DOWN: gain_q <= gain_q - gain_t'(1);
                default:   gain_q <= gain_q;
            endcase
        end
    end

    assign gain = gain_q;

endmodule

// File: rtl/sgs_chan_path.sv
module sgs_chan_path
    import sgs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    valid,
    input  logic    invert,
    input  sample_t sample_in,
    input  gain_t   gain,
    output sample_t sample_out
);

    sample_t oriented;
    sample_t out_q;

    always_comb begin
        oriented = invert ? neg_sat(sample_in) : sample_in;
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= '0;
        else if (valid)
            out_q <= apply_gain(oriented, gain);
    end

    assign sample_out = out_q;

endmodule

// File: rtl/sgs_zero_watch.sv
module sgs_zero_watch #(
    parameter int ZERO_FRAMES = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic valid,
    input  logic left_zero,
    input  logic right_zero,
    output logic flag
);

    localparam int CNT_W = $clog2(ZERO_FRAMES + 1);
    typedef logic [CNT_W-1:0] cnt_t;
    localparam cnt_t CNT_LIMIT = cnt_t'(ZERO_FRAMES);

    cnt_t run_q;
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            flag_q <= 1'b0;
        end else if (valid) begin
            if (left_zero && right_zero) begin
                if (run_q != CNT_LIMIT)
                    run_q <= run_q + cnt_t'(1);
                flag_q <= (run_q == CNT_LIMIT);
            end else begin
                run_q  <= '0;
                flag_q <= 1'b0;
            end
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/stereo_gain_stage.sv
module stereo_gain_stage
    import sgs_pkg::*;
#(
    parameter int ZERO_FRAMES = 1024
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [DATA_W-1:0]       in_left,
    input  logic [DATA_W-1:0]       in_right,
    input  logic [VOL_W-1:0]        vol_left,
    input  logic [VOL_W-1:0]        vol_right,
    input  logic                    soft_mute,
    input  logic                    hard_mute,
    input  logic                    flip_polarity,
    output logic                    out_valid,
    output logic [DATA_W-1:0]       out_left,
    output logic [DATA_W-1:0]       out_right,
    output logic                    zero_flag
);

    localparam int NCH = 2;

    frame_t  frm;
    logic    muted;
    sample_t smp_in  [NCH];
    sample_t smp_out [NCH];
    gain_t   vol     [NCH];
    gain_t   gain_q  [NCH];
    logic    valid_q;

    assign frm.valid = in_valid;
    assign frm.left  = in_left;
    assign frm.right = in_right;
    assign muted     = soft_mute | hard_mute;

    assign smp_in[0] = frm.left;
    assign smp_in[1] = frm.right;
    assign vol[0]    = vol_left;
    assign vol[1]    = vol_right;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        sgs_gain_ramp u_ramp (
            .clk     (clk),
            .rst     (rst),
            .advance (frm.valid),
            .mute    (muted),
            .volume  (vol[ch]),
            .gain    (gain_q[ch])
        );

        sgs_chan_path u_path (
            .clk        (clk),
            .rst        (rst),
            .valid      (frm.valid),
            .invert     (flip_polarity),
            .sample_in  (smp_in[ch]),
            .gain       (gain_q[ch]),
            .sample_out (smp_out[ch])
        );
    end

    sgs_zero_watch #(
        .ZERO_FRAMES (ZERO_FRAMES)
    ) u_zero (
        .clk        (clk),
        .rst        (rst),
        .valid      (frm.valid),
        .left_zero  (frm.left == '0),
        .right_zero (frm.right == '0),
        .flag       (zero_flag)
    );

    always_ff @(posedge clk) begin
        if (rst)
            valid_q <= 1'b0;
        else
            valid_q <= frm.valid;
    end

    assign out_valid = valid_q;
    assign out_left  = smp_out[0];
    assign out_right = smp_out[1];

endmodule

// File: rtl/sgs_checker.sv
module sgs_checker
    import sgs_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [DATA_W-1:0]       in_left,
    input logic [DATA_W-1:0]       in_right,
    input logic                    soft_mute,
    input logic                    hard_mute,
    input logic                    out_valid,
    input logic [DATA_W-1:0]       out_left,
    input logic [DATA_W-1:0]       out_right,
    input logic                    zero_flag,
    input logic [VOL_W-1:0]        gain_l,
    input logic [VOL_W-1:0]        gain_r
);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r3_left_one_step: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (gain_l == $past(gain_l)) ||
                     (gain_l == gain_t'($past(gain_l) + gain_t'(1))) ||
                     (gain_l == gain_t'($past(gain_l) - gain_t'(1))));

    a_r3_right_one_step: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (gain_r == $past(gain_r)) ||
                     (gain_r == gain_t'($past(gain_r) + gain_t'(1))) ||
                     (gain_r == gain_t'($past(gain_r) - gain_t'(1))));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(gain_l) && $stable(gain_r));

    a_r5_no_rise_muted: assert property (@(posedge clk) disable iff (rst)
        in_valid && (soft_mute || hard_mute) |=>
            (gain_l <= $past(gain_l)) && (gain_r <= $past(gain_r)));

    a_r6_silent_at_zero: assert property (@(posedge clk) disable iff (rst)
        in_valid && (soft_mute || hard_mute) && gain_l == '0 && gain_r == '0 |=>
            out_left == '0 && out_right == '0);

    a_r8_flag_persists: assert property (@(posedge clk) disable iff (rst)
        in_valid && zero_flag && in_left == '0 && in_right == '0 |=> zero_flag);

    a_r9_flag_clears: assert property (@(posedge clk) disable iff (rst)
        in_valid && (in_left != '0 || in_right != '0) |=> !zero_flag);

endmodule

bind stereo_gain_stage sgs_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_left   (in_left),
    .in_right  (in_right),
    .soft_mute (soft_mute),
    .hard_mute (hard_mute),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right),
    .zero_flag (zero_flag),
    .gain_l    (gain_q[0]),
    .gain_r    (gain_q[1])
);

// File: tb/sim_stereo_gain_stage.sv
`timescale 1ns/1ps
module sim_stereo_gain_stage;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic [23:0]        in_left = '0;
    logic [23:0]        in_right = '0;
    logic [13:0]        vol_left = 14'd16383;
    logic [13:0]        vol_right = 14'd16383;
    logic               soft_mute = 1'b0;
    logic               hard_mute = 1'b0;
    logic               flip_polarity = 1'b0;
    logic               out_valid;
    logic signed [23:0] out_left;
    logic signed [23:0] out_right;
    logic               zero_flag;

    int  n_vec  = 0;
    int  n_bad  = 0;
    bit  done   = 1'b0;

    // model state
    int      m_gl   = 16383;
    int      m_gr   = 16383;
    int      m_run  = 0;
    bit      m_flag = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;

    stereo_gain_stage u0 (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_left       (in_left),
        .in_right      (in_right),
        .vol_left      (vol_left),
        .vol_right     (vol_right),
        .soft_mute     (soft_mute),
        .hard_mute     (hard_mute),
        .flip_polarity (flip_polarity),
        .out_valid     (out_valid),
        .out_left      (out_left),
        .out_right     (out_right),
        .zero_flag     (zero_flag)
    );

    task automatic check(input string tag, input string what,
                         input longint act, input longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic longint scale_ref(input longint x, input int g, input bit inv);
        longint v;
        v = x;
        if (inv) v = (x == -8388608) ? 8388607 : -x;
        return (v * g) / 16384;
    endfunction

    function automatic int step_ref(input int g, input int tgt);
        if (g < tgt) return g + 1;
        if (g > tgt) return g - 1;
        return g;
    endfunction

    function automatic longint next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return longint'($signed(seed[23:0]));
    endfunction

    task automatic run_frame(input longint l, input longint r, input string tag);
        longint el, er;
        bit     mt;
        el = scale_ref(l, m_gl, flip_polarity);
        er = scale_ref(r, m_gr, flip_polarity);
        mt = soft_mute | hard_mute;
        m_gl = step_ref(m_gl, mt ? 0 : int'(vol_left));
        m_gr = step_ref(m_gr, mt ? 0 : int'(vol_right));
        if (l == 0 && r == 0) begin
            if (m_run < 2000) m_run++;
        end else begin
            m_run = 0;
        end
        m_flag = (m_run > 1024);
        @(negedge clk);
        in_valid = 1'b1;
        in_left  = l[23:0];
        in_right = r[23:0];
        @(posedge clk);
        #1;
        check(tag, "out_valid", longint'(out_valid), 1);
        check(tag, "out_left",  longint'(out_left),  el);
        check(tag, "out_right", longint'(out_right), er);
        check(tag, "zero_flag", longint'(zero_flag), longint'(m_flag));
    endtask

    task automatic run_idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_left  = 24'h5A5A5A;
            in_right = 24'hA5A5A5;
            @(posedge clk);
            #1;
            check(tag, "out_valid idle", longint'(out_valid), 0);
        end
    endtask

    function automatic longint edge_pat(input int i);
        case (i % 8)
            0: return 8388607;
            1: return -8388608;
            2: return -1;
            3: return 1;
            4: return 16383;
            5: return -16385;
            6: return 0;
            default: return next_rand();
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1", "out_left reset",  longint'(out_left),  0);
        check("R1", "out_right reset", longint'(out_right), 0);
        check("R1", "out_valid reset", longint'(out_valid), 0);
        check("R1", "zero_flag reset", longint'(zero_flag), 0);

        // R1 / R2: full-scale gain after reset, varied samples incl. rounding
        for (int i = 0; i < 64; i++)
            run_frame(edge_pat(i), edge_pat(i + 3), (i < 8) ? "R1" : "R2");

        // R3 / R4: left ramps down, right stays
        vol_left  = 14'd16000;
        vol_right = 14'd16383;
        for (int i = 0; i < 400; i++)
            run_frame(edge_pat(i), edge_pat(i + 5), "R4");

        // R3: idle cycles do not move the gain
        run_idle(5, "R3");
        for (int i = 0; i < 4; i++)
            run_frame(-8388608, 8388607, "R3");

        // R4: right ramps down independently
        vol_right = 14'd30;
        for (int i = 0; i < 16360; i++) begin
            run_frame(next_rand(), next_rand(), "R3");
            if (i % 997 == 0) run_idle(1, "R3");
        end

        vol_left = 14'd20;
        for (int i = 0; i < 15990; i++)
            run_frame(next_rand(), edge_pat(i), "R4");

        // R5: soft mute ramp to zero and recovery
        soft_mute = 1'b1;
        for (int i = 0; i < 35; i++)
            run_frame(edge_pat(i), edge_pat(i + 1), "R5");
        soft_mute = 1'b0;
        for (int i = 0; i < 40; i++)
            run_frame(8388607, -8388608, "R5");

        // R6: hard mute alone, then both, then release
        hard_mute = 1'b1;
        for (int i = 0; i < 40; i++)
            run_frame(-8388608, 8388607, "R6");
        soft_mute = 1'b1;
        for (int i = 0; i < 5; i++)
            run_frame(8388607, 8388607, "R6");
        hard_mute = 1'b0;
        for (int i = 0; i < 5; i++)
            run_frame(8388607, 8388607, "R6");
        soft_mute = 1'b0;
        for (int i = 0; i < 40; i++)
            run_frame(next_rand(), next_rand(), "R6");

        // R7: polarity flip, saturation of most negative code at full gain
        flip_polarity = 1'b1;
        for (int i = 0; i < 16; i++)
            run_frame(edge_pat(i), edge_pat(i + 2), "R7");
        vol_left  = 14'd16383;
        vol_right = 14'd16383;
        for (int i = 0; i < 16370; i++)
            run_frame(-8388608, (i % 2) ? 8388607 : -8388608, "R7");
        flip_polarity = 1'b0;
        for (int i = 0; i < 8; i++)
            run_frame(-8388608, edge_pat(i), "R7");

        // R8: zero flag boundary
        for (int i = 0; i < 1024; i++)
            run_frame(0, 0, "R8");
        run_frame(0, 0, "R8");
        check("R8", "zero_flag after 1025", longint'(zero_flag), 1);
        for (int i = 0; i < 10; i++)
            run_frame(0, 0, "R8");
        run_idle(3, "R8");
        check("R8", "zero_flag across idle", longint'(zero_flag), 1);

        // R9: one nonzero channel clears and restarts
        run_frame(5, 0, "R9");
        check("R9", "zero_flag left nonzero", longint'(zero_flag), 0);
        for (int i = 0; i < 600; i++)
            run_frame(0, 0, "R9");
        run_frame(0, -3, "R9");
        for (int i = 0; i < 1030; i++)
            run_frame(0, 0, "R9");
        run_frame(0, 1, "R9");

        @(negedge clk);
        in_valid = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule